// File: doc/BRIEF.md
# Sequential Radix-2 Integer Divider

This block divides a double-width or single-width dividend by a single-width divisor. It resolves one quotient bit per clock with a restoring shift-and-subtract engine. Both operands can be treated as two's-complement or as unsigned numbers. A long/short select chooses between a dividend made of two words and one made of a single word. In short mode the single word is widened to double width before the iterations begin, so both sizes take exactly the same number of cycles.

A caller sets the operands and the two mode selects, then pulses `start_i`. The block captures everything on the edge that accepts the start. It holds `busy_o` high while it works and raises `done_o` for one cycle when the quotient, remainder and flags are ready. The results stay on the outputs until the next operation completes. Division by zero and a quotient that does not fit the result width are reported on separate flags. The operand registers and the instruction decoding sit outside the block.

Top module: `seq_int_divider`

## Requirements
- R1: In unsigned mode with `long_i`=1, the dividend is {`dividend_hi_i`,`dividend_lo_i`} (high word in the upper bits). When neither flag is raised, `quotient_o` = floor(dividend / divisor) and `remainder_o` = dividend − quotient × divisor.
- R2: In signed mode both operands are two's complement and the quotient truncates toward zero. The remainder carries the sign of the dividend and satisfies dividend = quotient × divisor + remainder.
- R3: With `long_i`=0 only `dividend_lo_i` is used. It is sign-extended when `signed_i`=1 and zero-extended otherwise, and `dividend_hi_i` has no effect on any output.
- R4: `done_o` is high for exactly one cycle. That cycle follows the (DW+1)-th rising edge after the edge that accepts `start_i`, for long and short operations alike.
- R5: `busy_o` is high in every cycle from the accepting edge up to the done cycle, and low in the done cycle.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running result is unchanged and no extra `done_o` pulse follows.
- R7: A zero divisor raises `div_zero_o`, drives `quotient_o` and `remainder_o` to all ones, and keeps `overflow_o` low.
- R8: `overflow_o` is raised when the exact quotient is outside 0..2^DW−1 (unsigned mode) or outside −2^(DW−1)..2^(DW−1)−1 (signed mode). The quotient and remainder are then unspecified.
- R9: Operands and mode selects are captured at the accepting edge, so later input changes do not affect the result. Result outputs and flags change only in a done cycle.
- R10: After reset the block is idle, with `busy_o`, `done_o`, both flags, the quotient and the remainder all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; taken only when idle |
| long_i | input | 1 | 1: double-width dividend, 0: single-width dividend |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend_hi_i | input | DW | Upper word of the dividend (long mode only) |
| dividend_lo_i | input | DW | Lower word of the dividend |
| divisor_i | input | DW | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| quotient_o | output | DW | Quotient |
| remainder_o | output | DW | Remainder |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Quotient out of range |

## Verification
The following are checked by assertions on every cycle:
- the one-cycle width of `done_o`;
- the fixed distance from acceptance to completion;
- results changing only in a done cycle;
- a zero divisor never also raising overflow;
- `busy_o` being low in the done cycle;
- the partial remainder staying below the divisor during every in-range iteration.

The arithmetic itself can only be shown by the bench's scenarios. These include:
- truncation and remainder sign for every sign combination;
- sign or zero extension of short dividends;
- the overflow boundary at the most negative quotient;
- the fact that a start issued mid-operation, or operands changed after acceptance, leave the result untouched.

The bench sweeps every operand pair of a narrow configuration in all four modes.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ITER  = 2'd1,
      ST_FINAL = 2'd2
   } idiv_state_e;

   typedef struct packed {
      logic sgn;      // operation is signed
      logic neg_q;    // quotient must be negated
      logic neg_r;    // remainder must be negated
      logic pre_ovf;  // magnitude quotient exceeds DW bits
      logic dz;       // divisor is zero
   } idiv_flags_t;

endpackage

// File: rtl/idiv_operand.sv
module idiv_operand #(
   parameter int DW = 16
) (
   input  logic                 sgn_i,
   input  logic                 long_i,
   input  logic [DW-1:0]        hi_i,
   input  logic [DW-1:0]        lo_i,
   input  logic [DW-1:0]        dvs_i,
   output logic [2*DW-1:0]      mag_dvd_o,
   output logic [DW-1:0]        mag_dvs_o,
   output idiv_pkg::idiv_flags_t flags_o
);
   localparam int FW = 2 * DW;

   logic [FW-1:0] full;
   logic [DW-1:0] ext;
   logic          neg_a;
   logic          neg_b;

   always_comb begin
      ext       = {DW{sgn_i & lo_i[DW-1]}};
      full      = long_i ? {hi_i, lo_i} : {ext, lo_i};
      neg_a     = sgn_i & full[FW-1];
      neg_b     = sgn_i & dvs_i[DW-1];
      mag_dvd_o = neg_a ? -full : full;
      mag_dvs_o = neg_b ? -dvs_i : dvs_i;
      flags_o.sgn     = sgn_i;
      flags_o.neg_q   = neg_a ^ neg_b;
      flags_o.neg_r   = neg_a;
      flags_o.dz      = (dvs_i == '0);
      flags_o.pre_ovf = (mag_dvd_o[FW-1:DW] >= mag_dvs_o);
   end

endmodule

// File: rtl/idiv_engine.sv
module idiv_engine #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic            in_range_i,
   input  logic [2*DW-1:0] dvd_i,
   input  logic [DW-1:0]   dvs_i,
   output logic [DW-1:0]   quo_o,
   output logic [DW-1:0]   rem_o
);
   logic [DW-1:0] part_q;
   logic [DW-1:0] shr_q;
   logic [DW-1:0] dvr_q;
   logic [DW:0]   cat;
   logic [DW+1:0] diff;
   logic          ge;

   always_comb begin
      cat  = {part_q, shr_q[DW-1]};
      diff = {1'b0, cat} - {2'b00, dvr_q};
      ge   = ~diff[DW+1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         shr_q  <= '0;
         dvr_q  <= '0;
      end else if (load_i) begin
         part_q <= dvd_i[2*DW-1:DW];
         shr_q  <= dvd_i[DW-1:0];
         dvr_q  <= dvs_i;
      end else if (step_i) begin
         part_q <= ge ? diff[DW-1:0] : cat[DW-1:0];
         shr_q  <= {shr_q[DW-2:0], ge};
      end
   end

   assign quo_o = shr_q;
   assign rem_o = part_q;

   // R1
   part_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && in_range_i) |-> (part_q < dvr_q));

endmodule

// File: rtl/idiv_result.sv
module idiv_result #(
   parameter int DW = 16
) (
   input  logic [DW-1:0]         qm_i,
   input  logic [DW-1:0]         rm_i,
   input  idiv_pkg::idiv_flags_t flags_i,
   output logic [DW-1:0]         quo_o,
   output logic [DW-1:0]         rem_o,
   output logic                  dz_o,
   output logic                  ovf_o
);
   localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

   logic range_bad;

   always_comb begin
      range_bad = flags_i.neg_q ? (qm_i > HALF) : qm_i[DW-1];
      dz_o      = flags_i.dz;
      ovf_o     = !flags_i.dz & (flags_i.pre_ovf | (flags_i.sgn & range_bad));
      if (flags_i.dz) begin
         quo_o = '1;
         rem_o = '1;
      end else begin
         quo_o = flags_i.neg_q ? -qm_i : qm_i;
         rem_o = flags_i.neg_r ? -rm_i : rm_i;
      end
   end

endmodule

// File: rtl/seq_int_divider.sv
module seq_int_divider #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          long_i,
   input  logic          signed_i,
   input  logic [DW-1:0] dividend_hi_i,
   input  logic [DW-1:0] dividend_lo_i,
   input  logic [DW-1:0] divisor_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] quotient_o,
   output logic [DW-1:0] remainder_o,
   output logic          div_zero_o,
   output logic          overflow_o
);
   import idiv_pkg::*;

   localparam int CW = (DW > 1) ? $clog2(DW) : 1;
   localparam int LW = CW + 2;

   generate
      if (DW < 2) begin : g_dw_chk
         $error("seq_int_divider: DW must be at least 2");
      end
   endgenerate

   idiv_state_e     state_q;
   logic [CW-1:0]   cnt_q;
   idiv_flags_t     flags_in;
   idiv_flags_t     flags_q;
   logic [2*DW-1:0] mag_dvd;
   logic [DW-1:0]   mag_dvs;
   logic [DW-1:0]   qm;
   logic [DW-1:0]   rm;
   logic [DW-1:0]   res_q;
   logic [DW-1:0]   res_r;
   logic            res_dz;
   logic            res_ovf;
   logic            accept;
   logic            step;

   assign accept = start_i && (state_q == ST_IDLE);
   assign step   = (state_q == ST_ITER);
   assign busy_o = (state_q != ST_IDLE);

   idiv_operand #(.DW(DW)) u_operand (
      .sgn_i     (signed_i),
      .long_i    (long_i),
      .hi_i      (dividend_hi_i),
      .lo_i      (dividend_lo_i),
      .dvs_i     (divisor_i),
      .mag_dvd_o (mag_dvd),
      .mag_dvs_o (mag_dvs),
      .flags_o   (flags_in)
   );

   idiv_engine #(.DW(DW)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .step_i     (step),
      .in_range_i (!flags_q.pre_ovf && !flags_q.dz),
      .dvd_i      (mag_dvd),
      .dvs_i      (mag_dvs),
      .quo_o      (qm),
      .rem_o      (rm)
   );

   idiv_result #(.DW(DW)) u_result (
      .qm_i    (qm),
      .rm_i    (rm),
      .flags_i (flags_q),
      .quo_o   (res_q),
      .rem_o   (res_r),
      .dz_o    (res_dz),
      .ovf_o   (res_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         flags_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_ITER;
               cnt_q   <= '0;
               flags_q <= flags_in;
            end
            ST_ITER: begin
               if (cnt_q == CW'(DW - 1)) state_q <= ST_FINAL;
               else                      cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         quotient_o  <= '0;
         remainder_o <= '0;
         div_zero_o  <= 1'b0;
         overflow_o  <= 1'b0;
      end else if (state_q == ST_FINAL) begin
         done_o      <= 1'b1;
         quotient_o  <= res_q;
         remainder_o <= res_r;
         div_zero_o  <= res_dz;
         overflow_o  <= res_ovf;
      end else begin
         done_o      <= 1'b0;
      end
   end

   // checker-side latency counter
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (accept) lat_q <= '0;
      else if (busy_o) lat_q <= lat_q + 1'b1;
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == LW'(DW + 1)));

   // R5
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(quotient_o) || !$stable(remainder_o) || !$stable(overflow_o)) |-> done_o);

   // R7
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && div_zero_o) |-> (!overflow_o && (quotient_o == '1) && (remainder_o == '1)));

endmodule

// File: tb/seq_int_divider_bench.sv
module seq_int_divider_bench;
   localparam int DW    = 4;
   localparam int CLK_P = 10;
   localparam int MSK   = (1 << DW) - 1;

   logic          clk;
   logic          rst_n;
   logic          start_i;
   logic          long_i;
   logic          signed_i;
   logic [DW-1:0] dividend_hi_i;
   logic [DW-1:0] dividend_lo_i;
   logic [DW-1:0] divisor_i;
   logic          busy_o;
   logic          done_o;
   logic [DW-1:0] quotient_o;
   logic [DW-1:0] remainder_o;
   logic          div_zero_o;
   logic          overflow_o;

   int  n_chk;
   int  n_fail;
   bit  fin;

   seq_int_divider #(.DW(DW)) u_seq_int_divider (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .long_i        (long_i),
      .signed_i      (signed_i),
      .dividend_hi_i (dividend_hi_i),
      .dividend_lo_i (dividend_lo_i),
      .divisor_i     (divisor_i),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .quotient_o    (quotient_o),
      .remainder_o   (remainder_o),
      .div_zero_o    (div_zero_o),
      .overflow_o    (overflow_o)
   );

   initial clk = 1'b0;
   always #(CLK_P / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic scramble();
      dividend_hi_i = DW'($urandom);
      dividend_lo_i = DW'($urandom);
      divisor_i     = DW'($urandom);
      long_i        = 1'($urandom);
      signed_i      = 1'($urandom);
   endtask

   // called at a falling edge with the block idle
   task automatic run_op(input bit sg, input bit lg, input logic [2*DW-1:0] a,
                         input logic [DW-1:0] b, input bit poke);
      logic signed [2*DW-1:0] sa;
      int  av, bv, qt, rt, n;
      bit  ez, eo;
      logic [DW-1:0] q_hold, r_hold;
      string rq;
      sa = a;
      if (lg) av = sg ? int'(sa) : int'(a);
      else    av = sg ? int'($signed(a[DW-1:0])) : int'(a[DW-1:0]);
      bv = sg ? int'($signed(b)) : int'(b);
      ez = (bv == 0);
      qt = 0;
      rt = 0;
      eo = 1'b0;
      if (!ez) begin
         qt = av / bv;
         rt = av % bv;
         if (sg) eo = (qt > (1 << (DW - 1)) - 1) || (qt < -(1 << (DW - 1)));
         else    eo = (qt > MSK);
      end
      rq = sg ? "R2" : (lg ? "R1" : "R3");

      signed_i      = sg;
      long_i        = lg;
      dividend_hi_i = lg ? a[2*DW-1:DW] : DW'($urandom);  // R3 high word ignored when short
      dividend_lo_i = a[DW-1:0];
      divisor_i     = b;
      start_i       = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      scramble();  // R9 inputs after acceptance
      n = 0;
      chk(busy_o == 1'b1, "R5", "busy after accept", int'(busy_o), 1);
      while (!done_o && n < 64) begin
         start_i = poke && (n == 2);  // R6 start while busy
         if (start_i) scramble();
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(n == DW + 1, "R4", "latency", n, DW + 1);
      chk(busy_o == 1'b0, "R5", "busy in done cycle", int'(busy_o), 0);
      chk(div_zero_o == ez, "R7", "div_zero flag", int'(div_zero_o), int'(ez));
      chk(overflow_o == eo, "R8", "overflow flag", int'(overflow_o), int'(eo));
      if (ez) begin
         chk(quotient_o == '1, "R7", "quotient on zero divisor", int'(quotient_o), MSK);
         chk(remainder_o == '1, "R7", "remainder on zero divisor", int'(remainder_o), MSK);
      end else if (!eo) begin
         chk(int'(quotient_o) == (qt & MSK), poke ? "R6" : rq, "quotient",
             int'(quotient_o), qt & MSK);
         chk(int'(remainder_o) == (rt & MSK), poke ? "R6" : rq, "remainder",
             int'(remainder_o), rt & MSK);
      end
      q_hold = quotient_o;
      r_hold = remainder_o;
      @(negedge clk);
      chk(done_o == 1'b0, poke ? "R6" : "R4", "done after pulse", int'(done_o), 0);
      chk(busy_o == 1'b0, "R6", "idle after done", int'(busy_o), 0);
      chk(quotient_o == q_hold && remainder_o == r_hold, "R9", "result held",
          int'(quotient_o), int'(q_hold));
   endtask

   initial begin
      n_chk = 0;
      n_fail = 0;
      fin = 1'b0;
      rst_n = 1'b0;
      start_i = 1'b0;
      long_i = 1'b0;
      signed_i = 1'b0;
      dividend_hi_i = '0;
      dividend_lo_i = '0;
      divisor_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle in reset", int'(busy_o), 0);
      chk(quotient_o == '0 && remainder_o == '0, "R10", "results in reset",
          int'(quotient_o), 0);
      chk(div_zero_o == 1'b0 && overflow_o == 1'b0, "R10", "flags in reset",
          int'(overflow_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle after reset", int'(busy_o), 0);
      for (int sg = 0; sg < 2; sg++) begin
         for (int lg = 0; lg < 2; lg++) begin
            for (int a = 0; a < (lg != 0 ? (1 << (2 * DW)) : (1 << DW)); a++) begin
               for (int b = 0; b <= MSK; b++) begin
                  run_op(sg[0], lg[0], (2*DW)'(a), DW'(b), (a % 7) == 3);
               end
            end
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      fin = 1'b1;
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule